// File: doc/BRIEF.md
# Twisted-Pair Link Pulse Generator and Link Integrity Monitor

This block keeps track of whether a 10 Mb/s twisted-pair segment is connected. On the transmit side it sends a short idle pulse at a fixed interval whenever the port has no frame to send. The interval timer is held at zero while a frame is being sent, so the next pulse comes one full interval after the end of that frame.

On the receive side it watches the incoming idle pulses and the receive-data-valid indication. It keeps a link-good flag that needs a run of well-spaced pulses to come up. The flag drops after a long silence. While the link is down, the enables for the transmitter, receiver and collision detection are all low. A force input bypasses the monitor and keeps the port working without any pulses from the far end.

All times are counted in clock cycles and set by parameters. At a 20 MHz clock the defaults are:
- a 100 ns pulse,
- a 16 ms interval,
- a 100 ms loss time,
- a 4 ms minimum pulse spacing.

Top module: `nlp_link_ctrl`

## Requirements
- R1: Each transmitted pulse on `lp_o` is high for exactly PULSE_CYC consecutive cycles.
- R2: While `tx_active_i` stays low, `lp_o` rises every PERIOD_CYC cycles. The first rise comes PERIOD_CYC clock edges after reset is released.
- R3: `lp_o` is low in every cycle in which `tx_active_i` is high. The next pulse rises PERIOD_CYC cycles after the last clock edge at which `tx_active_i` was sampled high.
- R4: After reset, `link_good_o`, `lp_o`, `tx_en_o`, `rx_en_o` and `col_en_o` are all 0.
- R5: A received pulse is the rising edge of `rx_lp_i`. `link_good_o` goes to 1 at the clock edge that samples the GOOD_PULSES-th consecutive valid received pulse, and not before.
- R6: A received rising edge is valid only if it comes at least MIN_GAP_CYC clock edges after the previous rising edge; the first edge after reset is always valid. An edge that comes too soon is rejected and resets the consecutive-valid count to zero.
- R7: When the link is good, `link_good_o` drops LOSS_CYC clock edges after the last valid received pulse or the last cycle in which `rx_dv_i` was sampled high.
- R8: Sampling `rx_dv_i` high restarts the loss timer in the same way a valid pulse does.
- R9: While `force_link_i` is 1, `link_good_o` and all three enables are 1, whatever the received pulses. When it is released, the outputs return to the monitor's own state.
- R10: `tx_en_o`, `rx_en_o` and `col_en_o` each equal `link_good_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_active_i | input | 1 | A frame is being transmitted |
| rx_lp_i | input | 1 | Received idle pulse, level from the line receiver |
| rx_dv_i | input | 1 | Received data valid |
| force_link_i | input | 1 | Hold the link good and bypass the monitor |
| lp_o | output | 1 | Transmitted idle pulse |
| link_good_o | output | 1 | Link integrity status |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Receiver enable |
| col_en_o | output | 1 | Collision detection enable |

## Verification
A wrong interval count shows up at the first idle pulse as an `lp_o` edge that is off by one or more cycles. A timer that does not clear on transmit shows up one interval after the frame ends. A wrong pulse-spacing or consecutive-pulse count shows up as `link_good_o` coming up one pulse early or late. That is visible one cycle after the offending edge on `rx_lp_i`. A wrong loss timer is seen at the single cycle where link-good should fall, and a wrong refresh from data valid shows up there as well. A force path fault is visible in the cycle that force changes.

// File: rtl/nlp_pkg.sv
package nlp_pkg;
  typedef struct packed {
    logic tx;
    logic rx;
    logic col;
  } path_en_t;

  function automatic path_en_t fan_en(input logic on);
    path_en_t e;
    e.tx  = on;
    e.rx  = on;
    e.col = on;
    return e;
  endfunction
endpackage

// File: rtl/nlp_tx_gen.sv
module nlp_tx_gen #(
  parameter int PULSE_CYC  = 2,
  parameter int PERIOD_CYC = 320000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_active_i,
  output logic lp_o
);
  localparam int CW = $clog2(PERIOD_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pw_q  <= '0;
    end else if (tx_active_i) begin
      cnt_q <= '0;
      pw_q  <= '0;
    end else begin
      if (cnt_q == CW'(PERIOD_CYC - 1)) begin
        cnt_q <= '0;
        pw_q  <= PW'(PULSE_CYC);
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (pw_q != '0) pw_q <= pw_q - 1'b1;
      end
    end
  end

  assign lp_o = (pw_q != '0) && !tx_active_i;

  p_rise_on_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lp_o) |-> $past(cnt_q) == CW'(PERIOD_CYC - 1));
  p_quiet_after_tx_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(tx_active_i) && !tx_active_i) |-> !lp_o);
  p_width_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pw_q <= PW'(PULSE_CYC));
endmodule

// File: rtl/nlp_rx_mon.sv
module nlp_rx_mon #(
  parameter int LOSS_CYC    = 2000000,
  parameter int MIN_GAP_CYC = 80000,
  parameter int GOOD_PULSES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_lp_i,
  input  logic rx_dv_i,
  output logic good_o
);
  localparam int LW = $clog2(LOSS_CYC + 1);
  localparam int GW = $clog2(MIN_GAP_CYC + 1);
  localparam int NW = $clog2(GOOD_PULSES + 1);

  logic          lp_q;
  logic [GW-1:0] since_q;
  logic [LW-1:0] idle_q;
  logic [NW-1:0] run_q;
  logic          good_q;
  logic          lp_rise, lp_valid, refresh, idle_max;

  assign lp_rise  = rx_lp_i && !lp_q;
  assign lp_valid = lp_rise && (since_q >= GW'(MIN_GAP_CYC));
  assign refresh  = lp_valid || rx_dv_i;
  assign idle_max = (idle_q == LW'(LOSS_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q    <= 1'b0;
      since_q <= GW'(MIN_GAP_CYC);
    end else begin
      lp_q <= rx_lp_i;
      if (lp_rise)                             since_q <= GW'(1);
      else if (since_q < GW'(MIN_GAP_CYC))     since_q <= since_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      run_q  <= '0;
      good_q <= 1'b0;
    end else begin
      if (refresh)        idle_q <= '0;
      else if (!idle_max) idle_q <= idle_q + 1'b1;

      if (good_q) begin
        if (!refresh && idle_max) begin
          good_q <= 1'b0;
          run_q  <= '0;
        end
      end else if (lp_rise && !lp_valid) begin
        run_q <= '0;
      end else if (lp_valid) begin
        if (run_q + 1'b1 >= NW'(GOOD_PULSES)) begin
          good_q <= 1'b1;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else if (idle_max) begin
        run_q <= '0;
      end
    end
  end

  assign good_o = good_q;

  p_good_needs_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(good_q) |-> $past(lp_valid));
  p_loss_after_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(good_q) |-> $past(idle_q) == LW'(LOSS_CYC - 1));
  p_gap_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    since_q <= GW'(MIN_GAP_CYC));
  p_run_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q < NW'(GOOD_PULSES));
endmodule

// File: rtl/nlp_path_gate.sv
module nlp_path_gate
  import nlp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     good_i,
  input  logic     force_i,
  output logic     link_o,
  output path_en_t en_o
);
  assign link_o = good_i || force_i;
  assign en_o   = fan_en(link_o);

  p_force_good_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |-> (en_o.tx && en_o.rx && en_o.col));
  p_down_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!good_i && !force_i) |-> (en_o == '0));
endmodule

// File: rtl/nlp_link_ctrl.sv
module nlp_link_ctrl
  import nlp_pkg::*;
#(
  parameter int PULSE_CYC   = 2,
  parameter int PERIOD_CYC  = 320000,
  parameter int LOSS_CYC    = 2000000,
  parameter int MIN_GAP_CYC = 80000,
  parameter int GOOD_PULSES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_active_i,
  input  logic rx_lp_i,
  input  logic rx_dv_i,
  input  logic force_link_i,
  output logic lp_o,
  output logic link_good_o,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic col_en_o
);
  logic     mon_good;
  path_en_t en;

  nlp_tx_gen #(.PULSE_CYC(PULSE_CYC), .PERIOD_CYC(PERIOD_CYC)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_active_i(tx_active_i), .lp_o(lp_o)
  );

  nlp_rx_mon #(.LOSS_CYC(LOSS_CYC), .MIN_GAP_CYC(MIN_GAP_CYC),
               .GOOD_PULSES(GOOD_PULSES)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_lp_i(rx_lp_i), .rx_dv_i(rx_dv_i),
    .good_o(mon_good)
  );

  nlp_path_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .good_i(mon_good), .force_i(force_link_i),
    .link_o(link_good_o), .en_o(en)
  );

  assign tx_en_o  = en.tx;
  assign rx_en_o  = en.rx;
  assign col_en_o = en.col;
endmodule

// File: tb/tb_nlp_link_ctrl.sv
module tb_nlp_link_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PW  = 2;
  localparam int PER = 40;
  localparam int LOSS = 120;
  localparam int GAP = 10;
  localparam int NGOOD = 2;

  logic clk = 0, rst_ni = 0;
  logic tx_active = 0, rx_lp = 0, rx_dv = 0, force_link = 0;
  logic lp, link_good, tx_en, rx_en, col_en;

  nlp_link_ctrl #(.PULSE_CYC(PW), .PERIOD_CYC(PER), .LOSS_CYC(LOSS),
                  .MIN_GAP_CYC(GAP), .GOOD_PULSES(NGOOD)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_active_i(tx_active), .rx_lp_i(rx_lp),
    .rx_dv_i(rx_dv), .force_link_i(force_link), .lp_o(lp),
    .link_good_o(link_good), .tx_en_o(tx_en), .rx_en_o(rx_en), .col_en_o(col_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    c;
    int    kind;
    bit    val;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  function automatic logic pick(int kind);
    case (kind)
      0: return lp;
      1: return link_good;
      2: return tx_en;
      3: return rx_en;
      default: return col_en;
    endcase
  endfunction

  function automatic void check(string req, int kind, logic act, logic expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s cyc=%0d sig=%0d actual=%b expected=%b", req, cyc, kind, act, expv);
    end
  endfunction

  function automatic void push(int c, int kind, bit val, string req);
    exp_t e;
    e.c = c; e.kind = kind; e.val = val; e.req = req;
    exp_q.push_back(e);
  endfunction

  // monitor: compare queued expectations at their cycle
  always @(negedge clk) begin
    if (rst_ni) begin
      while (exp_q.size() > 0 && exp_q[0].c <= cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.c < cyc) check({e.req, " missed"}, e.kind, 1'bx, e.val);
        else           check(e.req, e.kind, pick(e.kind), e.val);
      end
    end
  end

  task automatic step_to(int c);
    while (cyc != c) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic send_lp(int c);
    step_to(c);
    rx_lp = 1;
    step_to(c + 1);
    rx_lp = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired at cyc=%0d actual=hung expected=done", cyc);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    check("R4", 0, lp, 0);
    check("R4", 1, link_good, 0);
    check("R4", 2, tx_en, 0);
    check("R4", 3, rx_en, 0);
    check("R4", 4, col_en, 0);
    @(posedge clk); #1;
    rst_ni = 1;

    // transmit idle pulses
    push(PER - 1, 0, 0, "R2");
    push(PER, 0, 1, "R2");
    push(PER + 1, 0, 1, "R1");
    push(PER + 2, 0, 0, "R1");
    push(2 * PER, 0, 1, "R2");
    push(3 * PER, 0, 0, "R3");
    push(160, 0, 0, "R3");
    push(170 + PER - 1, 0, 0, "R3");
    push(170 + PER, 0, 1, "R3");
    step_to(3 * PER);
    tx_active = 1;
    step_to(170);
    tx_active = 0;
    step_to(250);

    // receive: first pulse, noise, then two valid pulses
    push(300, 1, 0, "R4");
    push(301, 1, 0, "R5");
    push(315, 1, 0, "R6");
    push(324, 1, 0, "R5");
    push(325, 1, 1, "R5");
    push(325, 2, 1, "R10");
    push(325, 3, 1, "R10");
    push(325, 4, 1, "R10");
    push(445, 1, 1, "R8");
    push(539, 1, 1, "R7");
    push(540, 1, 0, "R7");
    push(540, 2, 0, "R10");
    push(540, 4, 0, "R10");
    push(560, 1, 1, "R9");
    push(560, 3, 1, "R9");
    push(560, 4, 1, "R9");
    push(570, 1, 0, "R9");
    push(570, 2, 0, "R9");
    send_lp(300);
    send_lp(304);
    send_lp(314);
    send_lp(324);
    step_to(400);
    rx_dv = 1;
    step_to(420);
    rx_dv = 0;
    step_to(560);
    force_link = 1;
    step_to(570);
    force_link = 0;
    step_to(580);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R1 pending=%0d actual=left expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule